// File: doc/BRIEF.md
# Multiboot Configuration Retry Sequencer

This controller steers the power-up load of a device whose configuration image sits in external serial flash. Out of reset it opens a read burst at flash address zero and parses the image as it streams in. The image starts with a device identifier, then a load instruction, then the flash address of the next image, then a payload length. The payload follows, and a 16-bit CRC closes the image. An image that passes every check is accepted and the block reports done.

A CRC failure retries the load from the next-image address carried in the failing image's own header. Retries stop once a fixed attempt budget is spent. An identifier mismatch or an illegal instruction gives no usable next address, so the block stops and reports failure at once. After an image has been accepted, a low pulse on the active-low reconfigure input starts a fresh sequence at the next-image address of the accepted image.

The flash side is a level request with an address, answered by a stream of bytes qualified by a valid strobe. Gaps between bytes are allowed.

Top module: `boot_retry_seq`

## Requirements
- R1: While reset is asserted and until the first load starts, done, fail, rd_req, attempts and cause are all zero. The first read burst after reset requests address 0x000000.
- R2: The image is read as a byte stream in this order: bytes 0-3 are the identifier, most significant byte first, and must equal DEV_ID. Byte 4 is the instruction and must equal LOAD_OP. Bytes 5-7 are the 24-bit next-image address, most significant byte first. Bytes 8-9 are the payload length N, most significant byte first. N payload bytes follow, then two CRC bytes. An image that passes all checks raises done, with fail low and rd_req low.
- R3: An identifier mismatch ends the burst right after byte 3. It sets fail, sets cause to 1 and starts no further burst, even if attempts remain.
- R4: A byte 4 other than LOAD_OP sets fail and sets cause to 2. No further burst starts.
- R5: The CRC is CRC-16 with polynomial 0x1021, initial value 0xFFFF and MSB-first processing, computed over bytes 0 to 9+N and stored high byte first. On a mismatch with attempts below MAX_TRIES, cause becomes 3. The next burst then starts at the next-image address from the failing image, and attempts increments.
- R6: attempts counts the loads of the current sequence and never exceeds MAX_TRIES. When load number MAX_TRIES fails its CRC, fail is set with cause 3 and no further burst starts.
- R7: While done is high, reconfig_n held low for at least three clock cycles and then raised starts a new burst. That burst uses the next-image address of the accepted image. done drops and attempts restarts at 1.
- R8: Once fail is set it stays set until reset, and a reconfigure pulse has no effect: no burst starts and fail stays high.
- R9: Idle cycles with byte_vld low may fall between any two bytes without changing the outcome. rd_addr is stable while rd_req stays high.
- R10: A payload length of zero is legal: the two CRC bytes follow byte 9 directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rd_req | output | 1 | Read burst request, held high while bytes are wanted |
| rd_addr | output | ADDR_W | Start address of the current burst |
| byte_vld | input | 1 | Byte strobe from flash |
| byte_data | input | 8 | Byte from flash |
| reconfig_n | input | 1 | Active-low reconfigure request, asynchronous |
| done | output | 1 | Image accepted |
| fail | output | 1 | Sequence stopped: budget spent or jump blocked |
| attempts | output | CNT_W | Load attempts of the current sequence |
| cause | output | 2 | Last failure: 0 none, 1 identifier, 2 instruction, 3 CRC |

## Verification
A byte counter or length register that drifts shows up within one image. Either the burst ends early or late, which makes the burst count or the last burst address wrong, or the CRC residue fails on a good image and the block reports cause 3 with an extra attempt. A wrong held next-image address appears on rd_addr at the very next retry or reconfigure burst. A budget counter fault shows as a wrong attempts value at the end of the sequence and a wrong number of bursts. Each vector therefore compares the final status together with the burst count and the last burst address.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    typedef enum logic [1:0] {
        ST_START = 2'd0,
        ST_READ  = 2'd1,
        ST_DONE  = 2'd2,
        ST_FAIL  = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_ID   = 2'd1,
        CAUSE_OP   = 2'd2,
        CAUSE_CRC  = 2'd3
    } cause_e;

    // byte positions inside an image header
    localparam int ID_LAST   = 3;
    localparam int OP_POS    = 4;
    localparam int JMP_FIRST = 5;
    localparam int JMP_LAST  = 7;
    localparam int LEN_FIRST = 8;
    localparam int LEN_LAST  = 9;
    localparam int HDR_LEN   = 10;
    localparam int CRC_LEN   = 2;

endpackage

// File: rtl/boot_sync.sv
module boot_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic rise
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d.s1   = async_n;
        d.s2   = q.s1;
        d.prev = q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{s1: 1'b1, s2: 1'b1, prev: 1'b1};
        else        q <= d;
    end

    // high for one cycle when the synchronised level returns high
    assign rise = q.s2 & ~q.prev;
endmodule

// File: rtl/boot_crc16.sv
module boot_crc16 #(
    parameter logic [15:0] POLY = 16'h1021,
    parameter logic [15:0] INIT = 16'hFFFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       en,
    input  logic [7:0] data,
    output logic [15:0] crc_nxt
);
    logic [15:0] crc_q, crc_d;

    always_comb begin
        logic [15:0] c;
        c = crc_q ^ {data, 8'h00};
        for (int b = 0; b < 8; b++) begin
            c = c[15] ? ((c << 1) ^ POLY) : (c << 1);
        end
        crc_nxt = c;
        if (clear)   crc_d = INIT;
        else if (en) crc_d = c;
        else         crc_d = crc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= INIT;
        else        crc_q <= crc_d;
    end
endmodule

// File: rtl/boot_budget.sv
module boot_budget #(
    parameter int MAX_TRIES = 3,
    parameter int CNT_W     = $clog2(MAX_TRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             first,
    input  logic             bump,
    output logic [CNT_W-1:0] cnt,
    output logic             spent
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_TRIES);

    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (first)     cnt_d = CNT_W'(1);
        else if (bump) cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt   = cnt_q;
    assign spent = (cnt_q >= LIMIT);
endmodule

// File: rtl/boot_retry_seq.sv
module boot_retry_seq
    import boot_seq_pkg::*;
#(
    parameter int          ADDR_W    = 24,
    parameter int          MAX_TRIES = 3,
    parameter logic [31:0] DEV_ID    = 32'h1B0C_5A01,
    parameter logic [7:0]  LOAD_OP   = 8'hC3,
    parameter int          CNT_W     = $clog2(MAX_TRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              byte_vld,
    input  logic [7:0]        byte_data,
    input  logic              reconfig_n,
    output logic              done,
    output logic              fail,
    output logic [CNT_W-1:0]  attempts,
    output logic [1:0]        cause
);
    localparam int IDX_W = 17;
    localparam logic [IDX_W-1:0] I_ID_LAST   = IDX_W'(ID_LAST);
    localparam logic [IDX_W-1:0] I_OP        = IDX_W'(OP_POS);
    localparam logic [IDX_W-1:0] I_JMP_FIRST = IDX_W'(JMP_FIRST);
    localparam logic [IDX_W-1:0] I_JMP_LAST  = IDX_W'(JMP_LAST);
    localparam logic [IDX_W-1:0] I_LEN_FIRST = IDX_W'(LEN_FIRST);
    localparam logic [IDX_W-1:0] I_LEN_LAST  = IDX_W'(LEN_LAST);
    localparam logic [IDX_W-1:0] I_HDR       = IDX_W'(HDR_LEN);
    localparam logic [IDX_W-1:0] I_TAIL      = IDX_W'(HDR_LEN + CRC_LEN - 1);

    typedef struct packed {
        seq_state_e        state;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] jump;
        logic [IDX_W-1:0]  idx;
        logic [23:0]       id_sh;
        logic [15:0]       jmp_sh;
        logic [7:0]        len_hi;
        logic [15:0]       len;
        cause_e            cause;
        logic              fresh;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        state: ST_START, base: '0, jump: '0, idx: '0, id_sh: '0,
        jmp_sh: '0, len_hi: '0, len: '0, cause: CAUSE_NONE, fresh: 1'b1
    };

    seq_t q, d;

    logic              rc_rise;
    logic              crc_clr, crc_en;
    logic [15:0]       crc_nxt;
    logic              bud_first, bud_bump, bud_spent;
    logic [CNT_W-1:0]  bud_cnt;
    logic [IDX_W-1:0]  last_idx;

    boot_sync i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_n (reconfig_n),
        .rise    (rc_rise)
    );

    boot_crc16 i_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (crc_clr),
        .en      (crc_en),
        .data    (byte_data),
        .crc_nxt (crc_nxt)
    );

    boot_budget #(.MAX_TRIES(MAX_TRIES), .CNT_W(CNT_W)) i_budget (
        .clk   (clk),
        .rst_n (rst_n),
        .first (bud_first),
        .bump  (bud_bump),
        .cnt   (bud_cnt),
        .spent (bud_spent)
    );

    assign last_idx = I_TAIL + IDX_W'(q.len);

    always_comb begin
        d         = q;
        crc_clr   = 1'b0;
        crc_en    = 1'b0;
        bud_first = 1'b0;
        bud_bump  = 1'b0;
        case (q.state)
            ST_START: begin
                crc_clr   = 1'b1;
                bud_first = q.fresh;
                bud_bump  = ~q.fresh;
                d.fresh   = 1'b0;
                d.idx     = '0;
                d.state   = ST_READ;
            end
            ST_READ: begin
                if (byte_vld) begin
                    crc_en = 1'b1;
                    d.idx  = q.idx + IDX_W'(1);
                    if (q.idx < I_ID_LAST) begin
                        d.id_sh = {q.id_sh[15:0], byte_data};
                    end
                    if (q.idx == I_ID_LAST && {q.id_sh, byte_data} != DEV_ID) begin
                        d.cause = CAUSE_ID;
                        d.state = ST_FAIL;
                    end
                    if (q.idx == I_OP && byte_data != LOAD_OP) begin
                        d.cause = CAUSE_OP;
                        d.state = ST_FAIL;
                    end
                    if (q.idx >= I_JMP_FIRST && q.idx < I_JMP_LAST) begin
                        d.jmp_sh = {q.jmp_sh[7:0], byte_data};
                    end
                    if (q.idx == I_JMP_LAST) begin
                        d.jump = ADDR_W'({q.jmp_sh, byte_data});
                    end
                    if (q.idx == I_LEN_FIRST) begin
                        d.len_hi = byte_data;
                    end
                    if (q.idx == I_LEN_LAST) begin
                        d.len = {q.len_hi, byte_data};
                    end
                    if (q.idx >= I_HDR && q.idx == last_idx) begin
                        if (crc_nxt == 16'h0000) begin
                            d.state = ST_DONE;
                        end else begin
                            d.cause = CAUSE_CRC;
                            if (bud_spent) begin
                                d.state = ST_FAIL;
                            end else begin
                                d.base  = q.jump;
                                d.state = ST_START;
                            end
                        end
                    end
                end
            end
            ST_DONE: begin
                if (rc_rise) begin
                    d.base  = q.jump;
                    d.fresh = 1'b1;
                    d.state = ST_START;
                end
            end
            default: begin
                d.state = ST_FAIL;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEQ_RST;
        else        q <= d;
    end

    assign rd_req   = (q.state == ST_READ);
    assign rd_addr  = q.base;
    assign done     = (q.state == ST_DONE);
    assign fail     = (q.state == ST_FAIL);
    assign attempts = bud_cnt;
    assign cause    = q.cause;
endmodule

// File: rtl/boot_retry_seq_chk.sv
module boot_retry_seq_chk #(
    parameter int ADDR_W    = 24,
    parameter int MAX_TRIES = 3,
    parameter int CNT_W     = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              done,
    input logic              fail,
    input logic [CNT_W-1:0]  attempts,
    input logic [1:0]        cause
);
    // R6
    attempts_in_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        attempts <= CNT_W'(MAX_TRIES));

    // R2
    done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    // R2
    done_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(rd_req));

    // R9
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && $past(rd_req)) |-> $stable(rd_addr));

    // R3
    fail_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> !rd_req);

    // R3
    fail_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (cause != 2'd0));

    // R8
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> fail);

    // R7
    done_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rd_req);
endmodule

bind boot_retry_seq boot_retry_seq_chk #(
    .ADDR_W(ADDR_W), .MAX_TRIES(MAX_TRIES), .CNT_W(CNT_W)
) i_boot_retry_seq_chk (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
    .done(done), .fail(fail), .attempts(attempts), .cause(cause)
);

// File: tb/test_boot_retry_seq.sv
module test_boot_retry_seq;
    localparam int          ADDR_W    = 24;
    localparam int          MAX_TRIES = 3;
    localparam int          CNT_W     = 2;
    localparam logic [31:0] DEV_ID    = 32'h1B0C_5A01;
    localparam logic [7:0]  LOAD_OP   = 8'hC3;

    // vector: tag[24:21] k0[20:19] k1[18:17] k2[16:15] gap[14] plen[13:6]
    //         done[5] fail[4] att[3:2] cause[1:0]
    // kinds: 0 good, 1 bad identifier, 2 bad instruction, 3 bad CRC
    localparam int NV = 11;
    localparam logic [24:0] VEC [0:NV-1] = '{
        {4'd2,  2'd0, 2'd0, 2'd0, 1'b0, 8'd5, 1'b1, 1'b0, 2'd1, 2'd0},
        {4'd9,  2'd0, 2'd0, 2'd0, 1'b1, 8'd6, 1'b1, 1'b0, 2'd1, 2'd0},
        {4'd10, 2'd0, 2'd0, 2'd0, 1'b0, 8'd0, 1'b1, 1'b0, 2'd1, 2'd0},
        {4'd5,  2'd3, 2'd0, 2'd0, 1'b0, 8'd3, 1'b1, 1'b0, 2'd2, 2'd3},
        {4'd5,  2'd3, 2'd3, 2'd0, 1'b1, 8'd2, 1'b1, 1'b0, 2'd3, 2'd3},
        {4'd6,  2'd3, 2'd3, 2'd3, 1'b0, 8'd1, 1'b0, 1'b1, 2'd3, 2'd3},
        {4'd3,  2'd1, 2'd0, 2'd0, 1'b0, 8'd4, 1'b0, 1'b1, 2'd1, 2'd1},
        {4'd4,  2'd2, 2'd0, 2'd0, 1'b0, 8'd4, 1'b0, 1'b1, 2'd1, 2'd2},
        {4'd3,  2'd3, 2'd1, 2'd0, 1'b0, 8'd2, 1'b0, 1'b1, 2'd2, 2'd1},
        {4'd4,  2'd3, 2'd2, 2'd0, 1'b1, 8'd3, 1'b0, 1'b1, 2'd2, 2'd2},
        {4'd6,  2'd3, 2'd3, 2'd1, 1'b0, 8'd0, 1'b0, 1'b1, 2'd3, 2'd1}
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic              byte_vld;
    logic [7:0]        byte_data;
    logic              reconfig_n;
    logic              done, fail;
    logic [CNT_W-1:0]  attempts;
    logic [1:0]        cause;

    always #10 clk = ~clk;

    boot_retry_seq #(
        .ADDR_W(ADDR_W), .MAX_TRIES(MAX_TRIES), .DEV_ID(DEV_ID),
        .LOAD_OP(LOAD_OP), .CNT_W(CNT_W)
    ) i_boot_retry_seq (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .byte_vld(byte_vld), .byte_data(byte_data), .reconfig_n(reconfig_n),
        .done(done), .fail(fail), .attempts(attempts), .cause(cause)
    );

    int checks = 0;
    int failures = 0;

    logic [7:0]  mem [0:2047];
    int          bursts;
    logic [23:0] first_addr, last_addr;
    logic        gap_mode = 1'b0;

    // flash model: streams bytes from the requested address while rd_req is high
    initial begin
        bit active;
        bit idle_next;
        int ptr;
        active = 0; idle_next = 0; ptr = 0;
        byte_vld = 1'b0; byte_data = 8'h00;
        forever begin
            @(negedge clk);
            if (rd_req) begin
                if (!active) begin
                    active = 1;
                    ptr = int'(rd_addr[10:0]);
                    idle_next = gap_mode;
                    if (bursts == 0) first_addr = rd_addr;
                    last_addr = rd_addr;
                    bursts++;
                end
                if (idle_next) begin
                    byte_vld = 1'b0;
                    idle_next = 0;
                end else begin
                    byte_vld = 1'b1;
                    byte_data = mem[ptr];
                    ptr = (ptr + 1) % 2048;
                    idle_next = gap_mode;
                end
            end else begin
                active = 0;
                byte_vld = 1'b0;
            end
        end
    end

    function automatic logic [15:0] crc_step(logic [15:0] c, logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int k = 7; k >= 0; k--) begin
            if (r[15] ^ b[k]) r = (r << 1) ^ 16'h1021;
            else              r = r << 1;
        end
        return r;
    endfunction

    task automatic put(int a, logic [7:0] v);
        mem[a % 2048] = v;
    endtask

    task automatic build_img(int base, int kind, logic [23:0] jmp, int plen);
        logic [15:0] c;
        logic [31:0] idv;
        idv = (kind == 1) ? (DEV_ID ^ 32'h0100_0000) : DEV_ID;
        put(base + 0, idv[31:24]);
        put(base + 1, idv[23:16]);
        put(base + 2, idv[15:8]);
        put(base + 3, idv[7:0]);
        put(base + 4, (kind == 2) ? (LOAD_OP ^ 8'h01) : LOAD_OP);
        put(base + 5, jmp[23:16]);
        put(base + 6, jmp[15:8]);
        put(base + 7, jmp[7:0]);
        put(base + 8, 8'(plen >> 8));
        put(base + 9, 8'(plen));
        for (int i = 0; i < plen; i++) put(base + 10 + i, 8'(base + 7 * i + 3));
        c = 16'hFFFF;
        for (int i = 0; i < 10 + plen; i++) c = crc_step(c, mem[(base + i) % 2048]);
        put(base + 10 + plen, c[15:8]);
        put(base + 11 + plen, c[7:0] ^ ((kind == 3) ? 8'h5A : 8'h00));
    endtask

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_name(int n);
        case (n)
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            9: return "R9";
            10: return "R10";
            default: return "R?";
        endcase
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        reconfig_n = 1'b1;
        bursts = 0;
        first_addr = '1;
        last_addr = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_end(string tag);
        int n;
        n = 0;
        @(negedge clk);
        while (!(done || fail) && n < 4000) begin
            @(negedge clk);
            n++;
        end
        chk(tag, "sequence ended", int'(done || fail), 1);
    endtask

    task automatic pulse_reconfig();
        @(negedge clk);
        reconfig_n = 1'b0;
        repeat (3) @(negedge clk);
        reconfig_n = 1'b1;
    endtask

    task automatic load_slots(int k0, int k1, int k2, int plen);
        build_img(12'h000, k0, 24'h000200, plen);
        build_img(12'h200, k1, 24'h000400, plen);
        build_img(12'h400, k2, 24'h000600, plen);
        build_img(12'h600, 0,  24'h000000, plen);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        reconfig_n = 1'b1;
        bursts = 0;

        // R1: reset state at the ports
        load_slots(0, 0, 0, 2);
        repeat (2) @(negedge clk);
        chk("R1", "done in reset", int'(done), 0);
        chk("R1", "fail in reset", int'(fail), 0);
        chk("R1", "rd_req in reset", int'(rd_req), 0);
        chk("R1", "attempts in reset", int'(attempts), 0);
        chk("R1", "cause in reset", int'(cause), 0);

        // vector table
        for (int r = 0; r < NV; r++) begin
            logic [24:0] v;
            string t;
            v = VEC[r];
            t = tag_name(int'(v[24:21]));
            gap_mode = v[14];
            load_slots(int'(v[20:19]), int'(v[18:17]), int'(v[16:15]), int'(v[13:6]));
            do_reset();
            wait_end(t);
            repeat (5) @(negedge clk);
            chk("R1", "first burst address", int'(first_addr), 0);
            chk(t, "done", int'(done), int'(v[5]));
            chk(t, "fail", int'(fail), int'(v[4]));
            chk(t, "attempts", int'(attempts), int'(v[3:2]));
            chk(t, "cause", int'(cause), int'(v[1:0]));
            chk(t, "burst count", bursts, int'(v[3:2]));
            chk(t, "last burst address", int'(last_addr), (int'(v[3:2]) - 1) * 32'h200);
            chk(t, "rd_req idle at end", int'(rd_req), 0);
        end
        gap_mode = 1'b0;

        // R7: reconfigure after acceptance jumps to the accepted image's next address
        begin
            int b0, n;
            load_slots(3, 0, 0, 3);
            do_reset();
            wait_end("R7");
            chk("R7", "accepted before reconfigure", int'(done), 1);
            b0 = bursts;
            pulse_reconfig();
            n = 0;
            while (!rd_req && n < 20) begin
                @(negedge clk);
                n++;
            end
            chk("R7", "burst started", int'(rd_req), 1);
            chk("R7", "done dropped", int'(done), 0);
            chk("R7", "attempts restarted", int'(attempts), 1);
            chk("R7", "reconfigure address", int'(rd_addr), 32'h400);
            wait_end("R7");
            chk("R7", "accepted again", int'(done), 1);
            chk("R7", "one extra burst", bursts, b0 + 1);
        end

        // R8: reconfigure ignored once failed
        begin
            int b0;
            load_slots(1, 0, 0, 2);
            do_reset();
            wait_end("R8");
            b0 = bursts;
            pulse_reconfig();
            repeat (30) @(negedge clk);
            chk("R8", "no burst after reconfigure", bursts, b0);
            chk("R8", "fail held", int'(fail), 1);
            chk("R8", "done low", int'(done), 0);
            chk("R8", "rd_req low", int'(rd_req), 0);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule